// File: doc/BRIEF.md
# Segment Register Table with Identifier-Swapping Remap

This block is the segment stage of a two-level address translator. A request carries an address-space number and a segment field. When the top bit of the segment field is set, the request falls into the shared region, whose number is all ones. Otherwise the region is the address-space number. The region and the low segment bits together form a global segment number. The low bits of that number select one entry of a directly indexed table. The stored tag is compared with the full global number to find collisions, the stored rights are checked against the access, and on success the entry's segment identifier is returned. The page stage hashes that identifier with the page number.

Software loads entries through a write port that sets the tag and the rights. The identifier field is never overwritten. A remap command moves a segment to a new global number by exchanging the identifiers of the source entry and the destination entry. The segment keeps its identifier, so page-stage entries that were built from it stay valid. Identifiers remain a permutation of the entry indices for the whole life of the table.

Top module: `segtab_remap`

## Requirements
- R1: After reset, `ready` stays low for exactly 2^IDX_W (256) cycles and then stays high. Every entry then starts with an invalid tag, no rights, and an identifier equal to its own index.
- R2: The global number is {region, seg[4:0]}, where region is 8'hFF when seg[5]=1 and the address-space number otherwise. The entry index is the low 8 bits of the global number.
- R3: A lookup whose entry is invalid, or whose stored tag differs from the request's global number, reports `rsp_miss` with `rsp_sid` = 0.
- R4: The rights bits are [0] read, [1] write, [2] execute and [3] supervisor-only. The access bits are `lk_acc`[0] read, [1] write and [2] execute, and `lk_sup`=1 means supervisor mode. A tag match reports `rsp_fault` if any requested access is not granted, or if the entry is supervisor-only and `lk_sup`=0.
- R5: A lookup is accepted at a clock edge, and its response is valid for one cycle after the next edge. While `rsp_valid` is high, exactly one of hit, miss and fault is set, and a hit carries the entry's identifier.
- R6: An accepted write stores the tag `wr_gsn` (valid) and the rights `wr_perm` at index `wr_gsn`[7:0]. The identifier at that index is left unchanged.
- R7: A remap whose source entry holds `rm_old_gsn` and whose two indices differ gives the destination entry tag `rm_new_gsn`, the source's identifier and the source's rights. The source entry becomes invalid and takes the destination's former identifier.
- R8: A remap whose source matches and whose two numbers share one index only replaces the tag with `rm_new_gsn`. The identifier and the rights are kept.
- R9: A remap whose source entry does not hold `rm_old_gsn` (or is invalid) changes no entry.
- R10: `busy` is high for exactly the two cycles after a remap is accepted. Commands presented while `busy` is high or `ready` is low are dropped: they make no change and give no response.
- R11: When several commands arrive in one cycle, remap wins over write, and write wins over lookup. The losing commands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 8 | Address-space number |
| lk_seg | input | 6 | Segment field; top bit selects the shared region |
| lk_acc | input | 3 | Requested access: read, write, execute |
| lk_sup | input | 1 | Requester is in supervisor mode |
| wr_en | input | 1 | Load tag and rights into one entry |
| wr_gsn | input | 13 | Global number to store |
| wr_perm | input | 4 | Rights to store |
| rm_en | input | 1 | Remap command |
| rm_old_gsn | input | 13 | Current global number of the segment |
| rm_new_gsn | input | 13 | New global number of the segment |
| ready | output | 1 | Initialisation walk finished |
| busy | output | 1 | Remap in progress |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Tag match with rights satisfied |
| rsp_miss | output | 1 | Invalid entry or index collision |
| rsp_fault | output | 1 | Tag match but rights violated |
| rsp_sid | output | 8 | Segment identifier on a hit, else zero |

## Verification
A wrong identifier in any entry shows only when a lookup hits that entry. For this reason the bench reloads every tag and reads back all 256 identifiers after the remaps. It compares them with a swap model and checks that they form a permutation. A lost or duplicated exchange therefore shows within one full sweep. A remap that writes the wrong side, or skips the invalidation, shows on the next lookup of the old or new number, three cycles after the command. A wrong busy length shows as a dropped or stale command on the cycle that follows.

// File: rtl/segtab_pkg.sv
package segtab_pkg;
  // write-mask bit positions for the shared write port
  localparam int M_TAG  = 0;
  localparam int M_SID  = 1;
  localparam int M_PERM = 2;
  localparam int MASK_W = 3;

  typedef enum logic [1:0] {
    RM_IDLE  = 2'd0,
    RM_READ  = 2'd1,
    RM_WRITE = 2'd2
  } rm_state_t;
endpackage

// File: rtl/segtab_xlate.sv
module segtab_xlate #(
  parameter int ASID_W = 8,
  parameter int SEGF_W = 6,
  parameter int IDX_W  = 8
) (
  input  logic [ASID_W-1:0]          asid,
  input  logic [SEGF_W-1:0]          segf,
  output logic [ASID_W+SEGF_W-2:0]   gsn,
  output logic [IDX_W-1:0]           idx
);
  localparam int SEGL_W = SEGF_W - 1;

  logic [ASID_W-1:0] region;

  always_comb begin
    region = segf[SEGF_W-1] ? {ASID_W{1'b1}} : asid;
    gsn    = {region, segf[SEGL_W-1:0]};
    idx    = gsn[IDX_W-1:0];
  end
endmodule

// File: rtl/segtab_store.sv
module segtab_store
  import segtab_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int GSN_W  = 13,
  parameter int SID_W  = 8,
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  // read port a: full entry
  input  logic              ra_en,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_vld,
  output logic [GSN_W-1:0]  ra_tag,
  output logic [SID_W-1:0]  ra_sid,
  output logic [PERM_W-1:0] ra_perm,
  // read port b: identifier only
  input  logic              rb_en,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [SID_W-1:0]  rb_sid,
  // write port a: masked fields
  input  logic              wa_en,
  input  logic [MASK_W-1:0] wa_mask,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic              wa_vld,
  input  logic [GSN_W-1:0]  wa_tag,
  input  logic [SID_W-1:0]  wa_sid,
  input  logic [PERM_W-1:0] wa_perm,
  // write port b: whole entry
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              wb_vld,
  input  logic [GSN_W-1:0]  wb_tag,
  input  logic [SID_W-1:0]  wb_sid,
  input  logic [PERM_W-1:0] wb_perm
);
  localparam int DEPTH = 1 << IDX_W;

  logic [GSN_W:0]    tag_mem  [DEPTH];
  logic [SID_W-1:0]  sid_mem  [DEPTH];
  logic [PERM_W-1:0] perm_mem [DEPTH];
  logic [IDX_W-1:0]  init_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_cnt <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == {IDX_W{1'b1}}) ready <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!ready) begin
      tag_mem[init_cnt]  <= '0;
      sid_mem[init_cnt]  <= SID_W'(init_cnt);
      perm_mem[init_cnt] <= '0;
    end else begin
      if (wa_en) begin
        if (wa_mask[M_TAG])  tag_mem[wa_idx]  <= {wa_vld, wa_tag};
        if (wa_mask[M_SID])  sid_mem[wa_idx]  <= wa_sid;
        if (wa_mask[M_PERM]) perm_mem[wa_idx] <= wa_perm;
      end
      if (wb_en) begin
        tag_mem[wb_idx]  <= {wb_vld, wb_tag};
        sid_mem[wb_idx]  <= wb_sid;
        perm_mem[wb_idx] <= wb_perm;
      end
    end
    if (ra_en) begin
      {ra_vld, ra_tag} <= tag_mem[ra_idx];
      ra_sid           <= sid_mem[ra_idx];
      ra_perm          <= perm_mem[ra_idx];
    end
    if (rb_en) rb_sid <= sid_mem[rb_idx];
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R7
  dual_write_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
endmodule

// File: rtl/segtab_check.sv
module segtab_check #(
  parameter int GSN_W  = 13,
  parameter int SID_W  = 8,
  parameter int ACC_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             p_valid,
  input  logic [GSN_W-1:0] p_gsn,
  input  logic [ACC_W-1:0] p_acc,
  input  logic             p_sup,
  input  logic             e_vld,
  input  logic [GSN_W-1:0] e_tag,
  input  logic [SID_W-1:0] e_sid,
  input  logic [ACC_W:0]   e_perm,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [SID_W-1:0] rsp_sid
);
  logic tag_ok, denied, sup_block, bad;

  always_comb begin
    tag_ok    = e_vld && (e_tag == p_gsn);
    denied    = |(p_acc & ~e_perm[ACC_W-1:0]);
    sup_block = e_perm[ACC_W] && !p_sup;
    bad       = denied || sup_block;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_sid   <= '0;
    end else begin
      rsp_valid <= p_valid;
      rsp_hit   <= p_valid && tag_ok && !bad;
      rsp_miss  <= p_valid && !tag_ok;
      rsp_fault <= p_valid && tag_ok && bad;
      rsp_sid   <= (p_valid && tag_ok && !bad) ? e_sid : '0;
    end
  end

  // R5
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

  // R5
  resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R3
  sid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_sid == '0));
endmodule

// File: rtl/segtab_remap_ctrl.sv
module segtab_remap_ctrl
  import segtab_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int GSN_W  = 13,
  parameter int SID_W  = 8,
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [GSN_W-1:0]  old_gsn,
  input  logic [GSN_W-1:0]  new_gsn,
  input  logic              o_vld,
  input  logic [GSN_W-1:0]  o_tag,
  input  logic [SID_W-1:0]  o_sid,
  input  logic [PERM_W-1:0] o_perm,
  input  logic [SID_W-1:0]  n_sid,
  output logic              busy,
  output logic              wa_en,
  output logic [MASK_W-1:0] wa_mask,
  output logic [IDX_W-1:0]  wa_idx,
  output logic              wa_vld,
  output logic [GSN_W-1:0]  wa_tag,
  output logic [SID_W-1:0]  wa_sid,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic              wb_vld,
  output logic [GSN_W-1:0]  wb_tag,
  output logic [SID_W-1:0]  wb_sid,
  output logic [PERM_W-1:0] wb_perm
);
  rm_state_t         state;
  logic [GSN_W-1:0]  old_q, new_q;
  logic              do_swap, do_retag;
  logic [SID_W-1:0]  sid_o_q, sid_n_q;
  logic [PERM_W-1:0] perm_q;
  logic              src_match, same_idx;

  always_comb begin
    src_match = o_vld && (o_tag == old_q);
    same_idx  = (old_q[IDX_W-1:0] == new_q[IDX_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RM_IDLE;
      busy     <= 1'b0;
      do_swap  <= 1'b0;
      do_retag <= 1'b0;
      old_q    <= '0;
      new_q    <= '0;
      sid_o_q  <= '0;
      sid_n_q  <= '0;
      perm_q   <= '0;
    end else begin
      unique case (state)
        RM_IDLE: if (go) begin
          state <= RM_READ;
          busy  <= 1'b1;
          old_q <= old_gsn;
          new_q <= new_gsn;
        end
        RM_READ: begin
          state    <= RM_WRITE;
          do_swap  <= src_match && !same_idx;
          do_retag <= src_match && same_idx;
          sid_o_q  <= o_sid;
          sid_n_q  <= n_sid;
          perm_q   <= o_perm;
        end
        RM_WRITE: begin
          state    <= RM_IDLE;
          busy     <= 1'b0;
          do_swap  <= 1'b0;
          do_retag <= 1'b0;
        end
        default: begin
          state <= RM_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    wa_en   = (state == RM_WRITE) && (do_swap || do_retag);
    wa_idx  = old_q[IDX_W-1:0];
    wa_mask = '0;
    wa_mask[M_TAG] = 1'b1;
    wa_mask[M_SID] = do_swap;
    wa_vld  = do_retag;
    wa_tag  = do_retag ? new_q : old_q;
    wa_sid  = sid_n_q;
    wb_en   = (state == RM_WRITE) && do_swap;
    wb_idx  = new_q[IDX_W-1:0];
    wb_vld  = 1'b1;
    wb_tag  = new_q;
    wb_sid  = sid_o_q;
    wb_perm = perm_q;
  end

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  // R7
  swap_invalidate_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wa_en && !wa_vld && wa_mask[M_SID]));
endmodule

// File: rtl/segtab_remap.sv
module segtab_remap
  import segtab_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int SEGF_W = 6,
  parameter int IDX_W  = 8,
  parameter int ACC_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_valid,
  input  logic [ASID_W-1:0]         lk_asid,
  input  logic [SEGF_W-1:0]         lk_seg,
  input  logic [ACC_W-1:0]          lk_acc,
  input  logic                      lk_sup,
  input  logic                      wr_en,
  input  logic [ASID_W+SEGF_W-2:0]  wr_gsn,
  input  logic [ACC_W:0]            wr_perm,
  input  logic                      rm_en,
  input  logic [ASID_W+SEGF_W-2:0]  rm_old_gsn,
  input  logic [ASID_W+SEGF_W-2:0]  rm_new_gsn,
  output logic                      ready,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_miss,
  output logic                      rsp_fault,
  output logic [IDX_W-1:0]          rsp_sid
);
  localparam int GSN_W  = ASID_W + SEGF_W - 1;
  localparam int SID_W  = IDX_W;
  localparam int PERM_W = ACC_W + 1;

  logic [GSN_W-1:0] lk_gsn;
  logic [IDX_W-1:0] lk_idx;
  logic             idle, rm_acc, wr_acc, lk_acc_ok;

  segtab_xlate #(.ASID_W(ASID_W), .SEGF_W(SEGF_W), .IDX_W(IDX_W)) u_xlate (
    .asid(lk_asid), .segf(lk_seg), .gsn(lk_gsn), .idx(lk_idx)
  );

  always_comb begin
    idle      = ready && !busy;
    rm_acc    = rm_en && idle;
    wr_acc    = wr_en && idle && !rm_en;
    lk_acc_ok = lk_valid && idle && !rm_en && !wr_en;
  end

  // request stage aligned with the registered table read
  logic             p_valid, p_sup;
  logic [GSN_W-1:0] p_gsn;
  logic [ACC_W-1:0] p_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_gsn   <= '0;
      p_acc   <= '0;
      p_sup   <= 1'b0;
    end else begin
      p_valid <= lk_acc_ok;
      if (lk_acc_ok) begin
        p_gsn <= lk_gsn;
        p_acc <= lk_acc;
        p_sup <= lk_sup;
      end
    end
  end

  logic              ra_en, rb_en, ra_vld;
  logic [IDX_W-1:0]  ra_idx, rb_idx;
  logic [GSN_W-1:0]  ra_tag;
  logic [SID_W-1:0]  ra_sid, rb_sid;
  logic [PERM_W-1:0] ra_perm;

  always_comb begin
    ra_en  = rm_acc || lk_acc_ok;
    ra_idx = rm_acc ? rm_old_gsn[IDX_W-1:0] : lk_idx;
    rb_en  = rm_acc;
    rb_idx = rm_new_gsn[IDX_W-1:0];
  end

  logic              c_wa_en, c_wa_vld, c_wb_en, c_wb_vld;
  logic [MASK_W-1:0] c_wa_mask;
  logic [IDX_W-1:0]  c_wa_idx, c_wb_idx;
  logic [GSN_W-1:0]  c_wa_tag, c_wb_tag;
  logic [SID_W-1:0]  c_wa_sid, c_wb_sid;
  logic [PERM_W-1:0] c_wb_perm;

  segtab_remap_ctrl #(.IDX_W(IDX_W), .GSN_W(GSN_W), .SID_W(SID_W), .PERM_W(PERM_W)) u_ctrl (
    .clk(clk), .rst(rst), .go(rm_acc),
    .old_gsn(rm_old_gsn), .new_gsn(rm_new_gsn),
    .o_vld(ra_vld), .o_tag(ra_tag), .o_sid(ra_sid), .o_perm(ra_perm), .n_sid(rb_sid),
    .busy(busy),
    .wa_en(c_wa_en), .wa_mask(c_wa_mask), .wa_idx(c_wa_idx), .wa_vld(c_wa_vld),
    .wa_tag(c_wa_tag), .wa_sid(c_wa_sid),
    .wb_en(c_wb_en), .wb_idx(c_wb_idx), .wb_vld(c_wb_vld), .wb_tag(c_wb_tag),
    .wb_sid(c_wb_sid), .wb_perm(c_wb_perm)
  );

  // port a is shared between the remap engine and software writes
  logic              wa_en, wa_vld;
  logic [MASK_W-1:0] wa_mask;
  logic [IDX_W-1:0]  wa_idx;
  logic [GSN_W-1:0]  wa_tag;
  logic [SID_W-1:0]  wa_sid;
  logic [PERM_W-1:0] wa_perm;

  always_comb begin
    if (c_wa_en) begin
      wa_en   = 1'b1;
      wa_mask = c_wa_mask;
      wa_idx  = c_wa_idx;
      wa_vld  = c_wa_vld;
      wa_tag  = c_wa_tag;
      wa_sid  = c_wa_sid;
      wa_perm = '0;
    end else begin
      wa_en   = wr_acc;
      wa_mask = '0;
      wa_mask[M_TAG]  = 1'b1;
      wa_mask[M_PERM] = 1'b1;
      wa_idx  = wr_gsn[IDX_W-1:0];
      wa_vld  = 1'b1;
      wa_tag  = wr_gsn;
      wa_sid  = '0;
      wa_perm = wr_perm;
    end
  end

  segtab_store #(.IDX_W(IDX_W), .GSN_W(GSN_W), .SID_W(SID_W), .PERM_W(PERM_W)) u_store (
    .clk(clk), .rst(rst), .ready(ready),
    .ra_en(ra_en), .ra_idx(ra_idx), .ra_vld(ra_vld), .ra_tag(ra_tag),
    .ra_sid(ra_sid), .ra_perm(ra_perm),
    .rb_en(rb_en), .rb_idx(rb_idx), .rb_sid(rb_sid),
    .wa_en(wa_en), .wa_mask(wa_mask), .wa_idx(wa_idx), .wa_vld(wa_vld),
    .wa_tag(wa_tag), .wa_sid(wa_sid), .wa_perm(wa_perm),
    .wb_en(c_wb_en), .wb_idx(c_wb_idx), .wb_vld(c_wb_vld), .wb_tag(c_wb_tag),
    .wb_sid(c_wb_sid), .wb_perm(c_wb_perm)
  );

  segtab_check #(.GSN_W(GSN_W), .SID_W(SID_W), .ACC_W(ACC_W)) u_check (
    .clk(clk), .rst(rst),
    .p_valid(p_valid), .p_gsn(p_gsn), .p_acc(p_acc), .p_sup(p_sup),
    .e_vld(ra_vld), .e_tag(ra_tag), .e_sid(ra_sid), .e_perm(ra_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_sid(rsp_sid)
  );

  // R10
  resp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid && ready && !busy && !rm_en && !wr_en, 2));

  // R11
  port_a_share_chk: assert property (@(posedge clk) disable iff (rst)
    !(c_wa_en && wr_en && !busy));
endmodule

// File: tb/tb_segtab_remap.sv
module tb_segtab_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_asid = '0;
  logic [5:0]  lk_seg = '0;
  logic [2:0]  lk_acc = '0;
  logic        lk_sup = 1'b0;
  logic        wr_en = 1'b0;
  logic [12:0] wr_gsn = '0;
  logic [3:0]  wr_perm = '0;
  logic        rm_en = 1'b0;
  logic [12:0] rm_old_gsn = '0;
  logic [12:0] rm_new_gsn = '0;
  logic        ready, busy, rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [7:0]  rsp_sid;

  segtab_remap dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_seg(lk_seg), .lk_acc(lk_acc), .lk_sup(lk_sup),
    .wr_en(wr_en), .wr_gsn(wr_gsn), .wr_perm(wr_perm),
    .rm_en(rm_en), .rm_old_gsn(rm_old_gsn), .rm_new_gsn(rm_new_gsn),
    .ready(ready), .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_sid(rsp_sid)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [256];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] gsn_of(input logic [7:0] a, input logic [5:0] s);
    logic [7:0] reg_n;
    reg_n = s[5] ? 8'hFF : a;
    return {reg_n, s[4:0]};
  endfunction

  task automatic do_write(input logic [12:0] g, input logic [3:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_gsn = g; wr_perm = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // response sampled one full cycle after the accepting edge
  task automatic do_lookup(input logic [7:0] a, input logic [5:0] s, input logic [2:0] acc,
                           input logic sup, output logic [3:0] flags, output logic [7:0] sid);
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = a; lk_seg = s; lk_acc = acc; lk_sup = sup;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    flags = {rsp_valid, rsp_hit, rsp_miss, rsp_fault};
    sid   = rsp_sid;
  endtask

  task automatic do_remap(input logic [12:0] o, input logic [12:0] n,
                          input bit poke, input logic [12:0] poke_gsn);
    @(negedge clk);
    rm_en = 1'b1; rm_old_gsn = o; rm_new_gsn = n;
    @(negedge clk);
    rm_en = 1'b0;
    chk("R10 busy first cycle", busy, 1);
    if (poke) begin wr_en = 1'b1; wr_gsn = poke_gsn; wr_perm = 4'b0111; end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 busy second cycle", busy, 1);
    @(negedge clk);
    chk("R10 busy released", busy, 0);
  endtask

  // rewrite every tag, then read back every identifier against the swap model
  task automatic sweep_ids(input string req);
    logic [3:0] f;
    logic [7:0] sid;
    bit seen [256];
    int dup;
    dup = 0;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    for (int i = 0; i < 256; i++) begin
      do_write({5'd0, 3'(i >> 5), 5'(i)}, 4'b0111);
      do_lookup({5'd0, 3'(i >> 5)}, {1'b0, 5'(i)}, 3'b000, 1'b0, f, sid);
      chk("R6 hit after write", f, 4'b1100);
      chk(req, sid, model[i]);
      if (seen[sid]) dup++;
      seen[sid] = 1'b1;
    end
    chk("R7 identifiers unique", dup, 0);
  endtask

  initial begin
    logic [3:0] f;
    logic [7:0] sid;
    logic [12:0] g;
    for (int i = 0; i < 256; i++) model[i] = 8'(i);

    repeat (4) @(negedge clk);
    chk("R1 ready low in reset", ready, 0);
    chk("R10 busy low in reset", busy, 0);
    chk("R5 no response in reset", rsp_valid, 0);
    rst = 1'b0;
    // lookup while initialising is dropped
    do_lookup(8'd0, 6'd0, 3'b000, 1'b0, f, sid);
    chk("R10 lookup dropped before ready", f, 4'b0000);
    repeat (252) @(negedge clk);
    chk("R1 ready low at cycle 255", ready, 0);
    @(negedge clk);
    chk("R1 ready high at cycle 256", ready, 1);

    // R1: all entries start invalid
    for (int i = 0; i < 256; i++) begin
      do_lookup({5'd0, 3'(i >> 5)}, {1'b0, 5'(i)}, 3'b000, 1'b1, f, sid);
      chk("R1 entry invalid after init", f, 4'b1010);
      chk("R3 sid zero on miss", sid, 0);
    end

    // R1/R6: identity identifiers survive tag loads
    sweep_ids("R1 identifier equals index");

    // R4: rights sweep on one entry
    g = gsn_of(8'd9, 6'd17);
    for (int p = 0; p < 16; p++) begin
      do_write(g, 4'(p));
      for (int a = 0; a < 8; a++) begin
        for (int s = 0; s < 2; s++) begin
          bit bad;
          bad = ((a & ~p & 7) != 0) || ((p & 8) != 0 && s == 0);
          do_lookup(8'd9, 6'd17, 3'(a), 1'(s), f, sid);
          chk("R4 rights outcome", f, bad ? 4'b1001 : 4'b1100);
          chk("R5 sid on hit", sid, bad ? 0 : model[8'h31]);
        end
      end
    end

    // R2: shared region forms region 255
    do_write({8'hFF, 5'd4}, 4'b0001);
    do_lookup(8'd7, 6'b100100, 3'b001, 1'b0, f, sid);
    chk("R2 shared region from any space", f, 4'b1100);
    do_lookup(8'd255, 6'b000100, 3'b001, 1'b0, f, sid);
    chk("R2 space 255 reaches shared region", f, 4'b1100);
    chk("R2 shared region sid", sid, model[8'hE4]);
    do_lookup(8'd7, 6'b000100, 3'b001, 1'b0, f, sid);
    chk("R3 private alias collides at same index", f, 4'b1010);

    // R3: collision on same index
    do_write({8'd2, 5'd3}, 4'b0111);
    do_lookup(8'd10, 6'd3, 3'b000, 1'b0, f, sid);
    chk("R3 collision miss", f, 4'b1010);
    chk("R3 collision sid zero", sid, 0);

    // R11: write beats lookup in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_gsn = {8'd6, 5'd20}; wr_perm = 4'b0111;
    lk_valid = 1'b1; lk_asid = 8'd6; lk_seg = 6'd20; lk_acc = 3'b000; lk_sup = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    @(negedge clk);
    chk("R11 lookup dropped beside write", rsp_valid, 0);
    do_lookup(8'd6, 6'd20, 3'b000, 1'b0, f, sid);
    chk("R11 write taken", f, 4'b1100);

    // R7: swap between 0x62 and 0xA9, with a write poked while busy (R10)
    do_lookup(8'd13, 6'd9, 3'b000, 1'b0, f, sid);
    chk("R3 destination collides before remap", f, 4'b1010);
    do_remap({8'd3, 5'd2}, {8'd13, 5'd9}, 1'b1, {8'd3, 5'd2});
    begin
      logic [7:0] t;
      t = model[8'h62]; model[8'h62] = model[8'hA9]; model[8'hA9] = t;
    end
    do_lookup(8'd13, 6'd9, 3'b111, 1'b0, f, sid);
    chk("R7 new number hits with source rights", f, 4'b1100);
    chk("R7 new number carries source sid", sid, 8'h62);
    do_lookup(8'd3, 6'd2, 3'b000, 1'b0, f, sid);
    chk("R10 write while busy dropped, R7 source invalid", f, 4'b1010);

    // R8: same-index remap keeps sid and rights
    do_remap({8'd13, 5'd9}, {8'd21, 5'd9}, 1'b0, '0);
    do_lookup(8'd21, 6'd9, 3'b111, 1'b0, f, sid);
    chk("R8 retag hit", f, 4'b1100);
    chk("R8 retag sid kept", sid, 8'h62);
    do_lookup(8'd13, 6'd9, 3'b000, 1'b0, f, sid);
    chk("R8 old tag gone", f, 4'b1010);

    // R9: non-matching source changes nothing
    do_remap({8'd200, 5'd7}, {8'd40, 5'd1}, 1'b0, '0);
    do_lookup(8'd40, 6'd1, 3'b000, 1'b0, f, sid);
    chk("R9 destination untouched", f, 4'b1010);
    do_lookup(8'd0, 6'd7, 3'b000, 1'b0, f, sid);
    chk("R9 source entry kept", sid, model[8'h07]);
    do_lookup(8'd0, 6'd1, 3'b000, 1'b0, f, sid);
    chk("R9 destination entry kept", sid, model[8'h01]);

    // R7: supervisor-only rights follow the segment
    do_write({8'd4, 5'd0}, 4'b1001);
    do_remap({8'd4, 5'd0}, {8'd12, 5'd30}, 1'b0, '0);
    begin
      logic [7:0] t;
      t = model[8'h80]; model[8'h80] = model[8'h9E]; model[8'h9E] = t;
    end
    do_lookup(8'd12, 6'd30, 3'b001, 1'b0, f, sid);
    chk("R7 supervisor right carried (user faults)", f, 4'b1001);
    do_lookup(8'd12, 6'd30, 3'b001, 1'b1, f, sid);
    chk("R7 supervisor access hits", sid, model[8'h9E]);

    // R11: remap beats write in the same cycle
    @(negedge clk);
    rm_en = 1'b1; rm_old_gsn = {8'd99, 5'd0}; rm_new_gsn = {8'd98, 5'd0};
    wr_en = 1'b1; wr_gsn = {8'd15, 5'd5}; wr_perm = 4'b0111;
    @(negedge clk);
    rm_en = 1'b0; wr_en = 1'b0;
    chk("R11 remap taken", busy, 1);
    repeat (2) @(negedge clk);
    do_lookup(8'd15, 6'd5, 3'b000, 1'b0, f, sid);
    chk("R11 write dropped beside remap", f, 4'b1010);

    // full identifier audit after all remaps
    sweep_ids("R7 identifier after swaps");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule